// File: doc/BRIEF.md
# UART Line Status Flag Logic

This block produces the transmit-side flags and the receive error summary bit of a 16550-style line status register, along with the interrupt request for an empty transmit buffer. It works in one of two modes, selected by a mode input. In the legacy mode a single holding register sits in front of the shift register. In the FIFO mode the flags follow the occupancy of a transmit FIFO and a count of error-tagged bytes waiting in the receive FIFO.

The surrounding UART supplies strobes for CPU writes to the holding register or FIFO, for moves from the holding register into the shift register, for receive FIFO pushes and pops with their error tags, and for status register reads. It also supplies a level that shows when the shift register is idle. The flags are outputs only. No write path can change them.

Top module: `uart_lsr_flags`

## Requirements
- R1: After reset, `thre` is 1, `err_sum` is 0 and `thre_irq` is 0. `temt` is 1 whenever `tsr_idle` is 1.
- R2: In legacy mode (`fifo_mode`=0), a `thr_wr` pulse makes `thre` 0 from the next cycle.
- R3: In legacy mode, a `thr_xfer` pulse without `thr_wr` makes `thre` 1 from the next cycle. When both pulse in the same cycle, `thre` is 0 afterwards.
- R4: In FIFO mode (`fifo_mode`=1), `thre` is 1 exactly when `txf_count` is 0, with no cycle of delay. Legacy strobes have no effect in this mode.
- R5: `temt` equals `thre` AND `tsr_idle` in both modes.
- R6: `thre_irq` equals `thre` AND `thre_ie`.
- R7: In legacy mode, `err_sum` is 0 and tagged receive pushes are not counted. The count is cleared while the mode input is 0.
- R8: In FIFO mode, a push with `rx_push_err`=1 sets `err_sum` from the next cycle. A push with `rx_push_err`=0 does not set it.
- R9: `err_sum` stays 1 while at least one tagged entry remains, even across `lsr_rd` pulses. Once the count reaches 0, `err_sum` holds until an `lsr_rd` pulse and is 0 from the cycle after that read.
- R10: A tagged push and a tagged pop in the same cycle leave the error count unchanged.
- R11: The error count saturates at `RX_DEPTH`. Tagged pushes beyond that are not counted, so `RX_DEPTH` tagged pops bring it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects legacy single-buffer mode |
| thr_wr | input | 1 | CPU write to the holding register (legacy mode) |
| thr_xfer | input | 1 | Holding register moved into the shift register |
| tsr_idle | input | 1 | Shift register holds no character |
| txf_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| rx_push | input | 1 | Byte pushed into the receive FIFO |
| rx_push_err | input | 1 | Pushed byte carries a parity, framing or break tag |
| rx_pop | input | 1 | Byte popped from the receive FIFO |
| rx_pop_err | input | 1 | Popped byte carried an error tag |
| lsr_rd | input | 1 | Status register read strobe |
| thre_ie | input | 1 | Empty-holding-register interrupt enable |
| thre | output | 1 | Transmit holding register / FIFO empty |
| temt | output | 1 | Transmitter fully empty |
| err_sum | output | 1 | Receive FIFO error summary (bit 7) |
| thre_irq | output | 1 | Interrupt request for the empty holding register |

## Verification
The assertions check on every cycle the relations that hold at any instant or across one edge. These are `temt` and `thre_irq` implying their sources, `thre` being 0 whenever the transmit FIFO is occupied, the legacy strobes taking effect one cycle later, `err_sum` staying low in legacy mode, a tagged push setting it, and the error count staying within bounds. The bench scenarios are needed for the history-dependent behaviour: the summary bit surviving reads while tags remain, lingering until the read after the count drains, cancelling of simultaneous push and pop, saturation, and the clearing of the count on a switch to legacy mode.

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int ERC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             thr_wr,
  input  logic             thr_xfer,
  input  logic             tsr_idle,
  input  logic [TXC_W-1:0] txf_count,
  input  logic             rx_push,
  input  logic             rx_push_err,
  input  logic             rx_pop,
  input  logic             rx_pop_err,
  input  logic             lsr_rd,
  input  logic             thre_ie,
  output logic             thre,
  output logic             temt,
  output logic             err_sum,
  output logic             thre_irq
);

  localparam logic [ERC_W-1:0] CNT_MAX = ERC_W'(RX_DEPTH);

  logic             hold_full;
  logic [ERC_W-1:0] err_cnt, err_cnt_nx;
  logic             err_q, err_nx;

  wire err_inc = fifo_mode & rx_push & rx_push_err;
  wire err_dec = fifo_mode & rx_pop & rx_pop_err;

  always_comb begin
    err_cnt_nx = err_cnt;
    if (!fifo_mode)
      err_cnt_nx = '0;
    else if (err_inc && !err_dec && err_cnt != CNT_MAX)
      err_cnt_nx = err_cnt + 1'b1;
    else if (err_dec && !err_inc && err_cnt != '0)
      err_cnt_nx = err_cnt - 1'b1;
  end

  assign err_nx = fifo_mode & ((err_cnt_nx != '0) | (err_q & ~lsr_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      err_cnt   <= '0;
      err_q     <= 1'b0;
    end else begin
      if (!fifo_mode) begin
        if (thr_wr)
          hold_full <= 1'b1;
        else if (thr_xfer)
          hold_full <= 1'b0;
      end
      err_cnt <= err_cnt_nx;
      err_q   <= err_nx;
    end
  end

  assign thre     = fifo_mode ? (txf_count == '0) : ~hold_full;
  assign temt     = thre & tsr_idle;
  assign thre_irq = thre & thre_ie;
  assign err_sum  = err_q & fifo_mode;

endmodule

// File: rtl/uart_lsr_flags_chk.sv
module uart_lsr_flags_chk #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int TXC_W = $clog2(TX_DEPTH + 1),
  parameter int ERC_W = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             thr_wr,
  input logic             thr_xfer,
  input logic             tsr_idle,
  input logic [TXC_W-1:0] txf_count,
  input logic             rx_push,
  input logic             rx_push_err,
  input logic             rx_pop,
  input logic             rx_pop_err,
  input logic             lsr_rd,
  input logic             thre_ie,
  input logic             thre,
  input logic             temt,
  input logic             err_sum,
  input logic             thre_irq,
  input logic [ERC_W-1:0] err_cnt
);

  assert_wr_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && thr_wr) |=> (fifo_mode || !thre));

  assert_xfer_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && thr_xfer && !thr_wr) |=> (fifo_mode || thre));

  assert_fifo_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && txf_count != '0) |-> !thre);

  assert_temt_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> (thre && tsr_idle));

  assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> (thre && thre_ie));

  assert_legacy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !err_sum);

  assert_tag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rx_push && rx_push_err && !(rx_pop && rx_pop_err))
      |=> (!fifo_mode || err_sum));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && err_sum && !lsr_rd) |=> (!fifo_mode || err_sum));

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= ERC_W'(RX_DEPTH));

endmodule

bind uart_lsr_flags uart_lsr_flags_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (.*);

// File: tb/uart_lsr_flags_test.sv
module uart_lsr_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam int TW = $clog2(TXD + 1);
  localparam int EW = $clog2(RXD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, thr_wr = 0, thr_xfer = 0, tsr_idle = 1;
  logic [TW-1:0] txf_count = '0;
  logic rx_push = 0, rx_push_err = 0, rx_pop = 0, rx_pop_err = 0;
  logic lsr_rd = 0, thre_ie = 0;
  logic thre, temt, err_sum, thre_irq;

  uart_lsr_flags #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_wr(thr_wr),
    .thr_xfer(thr_xfer), .tsr_idle(tsr_idle), .txf_count(txf_count),
    .rx_push(rx_push), .rx_push_err(rx_push_err), .rx_pop(rx_pop),
    .rx_pop_err(rx_pop_err), .lsr_rd(lsr_rd), .thre_ie(thre_ie),
    .thre(thre), .temt(temt), .err_sum(err_sum), .thre_irq(thre_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit chk;
    logic [3:0] exp;
    string tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit m_hold = 0, m_flag = 0;
  int m_cnt = 0;

  task automatic compare(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {thre,temt,err_sum,irq} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit chk, input string tag);
    item_t it;
    bit inc, dec, t;
    inc = fifo_mode && rx_push && rx_push_err;
    dec = fifo_mode && rx_pop && rx_pop_err;
    if (!fifo_mode) begin
      if (thr_wr) m_hold = 1;
      else if (thr_xfer) m_hold = 0;
    end
    if (!fifo_mode) m_cnt = 0;
    else if (inc && !dec && m_cnt < RXD) m_cnt++;
    else if (dec && !inc && m_cnt > 0) m_cnt--;
    m_flag = fifo_mode && (m_cnt != 0 || (m_flag && !lsr_rd));
    t = fifo_mode ? (txf_count == 0) : !m_hold;
    it.chk = chk;
    it.exp = {t, t & tsr_idle, m_flag, t & thre_ie};
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle_in();
    thr_wr = 0; thr_xfer = 0; rx_push = 0; rx_push_err = 0;
    rx_pop = 0; rx_pop_err = 0; lsr_rd = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.chk) compare({thre, temt, err_sum, thre_irq}, it.exp, it.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare({thre, temt, err_sum, thre_irq}, 4'b1100, "R1 reset");
    rst_n = 1;
    @(negedge clk);

    // legacy mode
    thr_wr = 1; tick(1, "R2 write clears thre");
    idle_in(); tick(1, "R2 thre stays clear");
    thre_ie = 1; tick(1, "R6 irq low when thre 0");
    thr_xfer = 1; tsr_idle = 0; tick(1, "R3 xfer sets thre / R5 temt low");
    idle_in(); tick(1, "R6 irq raised");
    tsr_idle = 1; tick(1, "R5 temt high");
    thr_wr = 1; thr_xfer = 1; tick(1, "R3 write and xfer together");
    idle_in(); thr_xfer = 1; tick(1, "R3 xfer after");
    idle_in();
    rx_push = 1; rx_push_err = 1; tick(1, "R7 legacy tag ignored");
    tick(1, "R7 legacy tag ignored again");
    idle_in(); thre_ie = 0; tick(1, "R6 irq gated");

    // FIFO mode
    fifo_mode = 1; tick(1, "R7 count cleared on mode change");
    txf_count = 3; tick(1, "R4 fifo occupied");
    thr_xfer = 1; tick(1, "R4 legacy strobe ignored");
    idle_in(); txf_count = 0; tsr_idle = 0; tick(1, "R4/R5 fifo empty shifter busy");
    tsr_idle = 1; tick(1, "R5 fifo temt");
    rx_push = 1; tick(1, "R8 untagged push");
    rx_push_err = 1; tick(1, "R8 tagged push sets");
    rx_push_err = 0; rx_push = 0; rx_pop = 1; rx_pop_err = 1;
    rx_push = 1; rx_push_err = 1; tick(1, "R10 push and pop cancel");
    idle_in(); lsr_rd = 1; tick(1, "R9 read with tags remaining");
    idle_in(); rx_pop = 1; rx_pop_err = 1; tick(1, "R9 count zero flag held");
    idle_in(); tick(1, "R9 still held");
    lsr_rd = 1; tick(1, "R9 read clears");
    idle_in(); tick(1, "R9 stays clear");

    // saturation
    rx_push = 1; rx_push_err = 1;
    for (int i = 0; i < RXD + 3; i++) tick(0, "R11 fill");
    idle_in(); rx_pop = 1; rx_pop_err = 1;
    for (int i = 0; i < RXD; i++) tick(i == RXD - 1, "R11 drain");
    idle_in(); lsr_rd = 1; tick(1, "R11 cleared after saturated drain");
    idle_in(); tick(1, "R11 final");

    // mode switch drops count
    rx_push = 1; rx_push_err = 1; tick(1, "R8 set again");
    idle_in(); fifo_mode = 0; tick(1, "R7 legacy forces zero");
    fifo_mode = 1; tick(1, "R7 count was cleared");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule